// File: doc/BRIEF.md
# Multi-Command SPI Transfer Sequencer

This block chains up to four SPI commands into one run. Software programs a bank of 16-bit command words, a 32-bit byte count for each command and a 3-bit field that gives the index of the last command to execute. A single start pulse then makes the sequencer visit commands in index order. For each command it presents the command word, the decoded bus mode (single, dual or quad), the transfer direction and the remaining byte count to an external shift engine. The engine reports every finished byte with a one-cycle pulse.

Chip select is driven from here. It rises when a command with a non-zero count begins. Between commands it either stays high or drops for one cycle, depending on the hold flag of the command that just finished. After the last command it is always released. The command pointer and an error code are packed into an 8-bit status word. A sequence-length value that points past the implemented slots is refused: the run does not start and the error code is raised.

Top module: `spi_cmd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, command-active, busy and done are low and the status word is 0x00.
- R2: A write places command slot i at address 0x10+2*i (low 16 bits of the write data), the byte count of slot i at address 0x20+4*i (32 bits) and the sequence length at address 0x08 (bits 2:0). While a command is active, the command output shows the word of the slot it came from.
- R3: A start pulse while idle, with sequence length L not above 3, executes slots 0 to L in ascending order. The mode output is command bits 6:5 (00 single, 01 dual, 10 quad). The read output is command bit 4 when the mode is not single, and 0 otherwise.
- R4: The byte-count output starts at the slot's count when a command becomes active and falls by one for each byte-done pulse. The command ends on the pulse that takes it to zero.
- R5: The status word carries the command pointer in bits 2:0 and the error code in bits 6:4, with bits 7 and 3 at zero. The pointer shows the slot being loaded or executed, and it is 0 while idle.
- R6: Chip select is high whenever a command is active. When a command that is not the last ends, chip select stays high if bit 7 of its word is 1 and is low for one cycle if bit 7 is 0.
- R7: A slot whose byte count is zero takes one cycle with its index on the pointer. It never becomes active, issues no bytes and leaves chip select unchanged.
- R8: After the last slot completes or is skipped, chip select goes low, the pointer returns to 0 and done is high for exactly one cycle.
- R9: A start while idle with a sequence length greater than 3 starts nothing and sets the error code to 1. The next accepted start clears it to 0.
- R10: With the configuration registers at their reset values (sequence length 0), a start executes slot 0 alone.
- R11: A start pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| seq_start | input | 1 | Start pulse for a run |
| byte_done | input | 1 | Engine finished one byte |
| cs_active | output | 1 | Chip select, active high |
| cmd_active | output | 1 | A command is being issued to the engine |
| cur_cmd | output | 16 | Word of the active command |
| cur_mode | output | 2 | Bus mode of the active command |
| cur_read | output | 1 | Active dual/quad command reads |
| bytes_left | output | 32 | Bytes still to transfer for the active command |
| seq_busy | output | 1 | A run is in progress |
| seq_done | output | 1 | One-cycle pulse when a run ends |
| seq_status | output | 8 | Pointer (2:0) and error code (6:4) |

## Verification
The assertions take three things for granted. The engine pulses byte_done only while cmd_active is high. Configuration registers are not written while a run is busy, because the pointer bound is checked against the sequence length. Start is a single-cycle pulse. The bench's engine model derives byte_done from the sampled cmd_active at its own byte rate, and every register write and every valid start comes after the done pulse or error of the run before. The one exception is the deliberate start issued mid-run, which has no effect on the sequencer.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_QUAD   = 2'b10,
    MODE_RSVD   = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // command word field positions
  localparam int KEEP_BIT = 7;
  localparam int MODE_HI  = 6;
  localparam int MODE_LO  = 5;
  localparam int DIR_BIT  = 4;

  localparam int PTR_W = 3;
  localparam int ERR_W = 3;

  localparam logic [ERR_W-1:0] ERR_NONE   = 3'd0;
  localparam logic [ERR_W-1:0] ERR_SEQLEN = 3'd1;

endpackage

// File: rtl/seq_regbank.sv
module seq_regbank
  import spi_seq_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter int ADDR_W   = 8,
  parameter int CMD_W    = 16,
  parameter int LEN_W    = 32,
  parameter int CMD_BASE = 16,
  parameter int LEN_BASE = 32,
  parameter int SEQ_ADDR = 8,
  localparam int IDX_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CMD_W-1:0]  slot_cmd,
  output logic [LEN_W-1:0]  slot_len,
  output logic [PTR_W-1:0]  seq_len
);

  logic [CMD_W-1:0] cmd_r [NUM_CMDS];
  logic [LEN_W-1:0] len_r [NUM_CMDS];

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_slot
    localparam int A_CMD = CMD_BASE + 2 * i;
    localparam int A_LEN = LEN_BASE + 4 * i;

    always_ff @(posedge clk) begin
      if (rst) begin
        cmd_r[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(A_CMD)) begin
        cmd_r[i] <= wr_data[CMD_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        len_r[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(A_LEN)) begin
        len_r[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_len <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(SEQ_ADDR)) begin
      seq_len <= wr_data[PTR_W-1:0];
    end
  end

  assign slot_cmd = cmd_r[rd_idx];
  assign slot_len = len_r[rd_idx];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter int CMD_W    = 16,
  parameter int LEN_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             byte_done,
  input  logic [PTR_W-1:0] seq_len,
  input  logic [CMD_W-1:0] slot_cmd,
  input  logic [LEN_W-1:0] slot_len,
  output logic [PTR_W-1:0] ptr_o,
  output logic             cs_o,
  output logic             active_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [LEN_W-1:0] left_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CMDS - 1);

  seq_state_e       state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             cs_q;
  logic [CMD_W-1:0] cmd_q;
  logic [LEN_W-1:0] left_q;
  logic             done_q;
  logic [ERR_W-1:0] err_q;
  logic             is_last;

  assign is_last = (ptr_q == seq_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cs_q    <= 1'b0;
      cmd_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (seq_len > LAST) begin
              err_q <= ERR_SEQLEN;
            end else begin
              err_q   <= ERR_NONE;
              ptr_q   <= '0;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (slot_len == '0) begin
            if (is_last) begin
              state_q <= ST_IDLE;
              ptr_q   <= '0;
              cs_q    <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end else begin
            cmd_q   <= slot_cmd;
            left_q  <= slot_len;
            cs_q    <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (byte_done) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
              if (is_last) begin
                state_q <= ST_IDLE;
                ptr_q   <= '0;
                cs_q    <= 1'b0;
                done_q  <= 1'b1;
              end else begin
                ptr_q   <= ptr_q + 1'b1;
                cs_q    <= cmd_q[KEEP_BIT];
                state_q <= ST_LOAD;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign cs_o     = cs_q;
  assign active_o = (state_q == ST_RUN);
  assign cmd_o    = cmd_q;
  assign left_o   = left_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R6
  cs_during_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> cs_q);

  // R4
  byte_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && byte_done) |=> (left_q == $past(left_q) - 1'b1));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!cs_q && ptr_q == '0 && state_q == ST_IDLE));

  // R9
  bad_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start && seq_len > LAST) |=>
      (state_q == ST_IDLE && err_q == ERR_SEQLEN));

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (ptr_q <= seq_len));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && start && !byte_done) |=> (state_q == ST_RUN));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter int ADDR_W   = 8,
  parameter int CMD_W    = 16,
  parameter int LEN_W    = 32,
  parameter int CMD_BASE = 16,
  parameter int LEN_BASE = 32,
  parameter int SEQ_ADDR = 8,
  localparam int IDX_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_data,
  input  logic              seq_start,
  input  logic              byte_done,
  output logic              cs_active,
  output logic              cmd_active,
  output logic [CMD_W-1:0]  cur_cmd,
  output logic [1:0]        cur_mode,
  output logic              cur_read,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              seq_busy,
  output logic              seq_done,
  output logic [7:0]        seq_status
);

  logic [CMD_W-1:0] slot_cmd;
  logic [LEN_W-1:0] slot_len;
  logic [PTR_W-1:0] seq_len;
  logic [PTR_W-1:0] ptr;
  logic [ERR_W-1:0] err;

  seq_regbank #(
    .NUM_CMDS (NUM_CMDS),
    .ADDR_W   (ADDR_W),
    .CMD_W    (CMD_W),
    .LEN_W    (LEN_W),
    .CMD_BASE (CMD_BASE),
    .LEN_BASE (LEN_BASE),
    .SEQ_ADDR (SEQ_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (ptr[IDX_W-1:0]),
    .slot_cmd (slot_cmd),
    .slot_len (slot_len),
    .seq_len  (seq_len)
  );

  seq_ctrl #(
    .NUM_CMDS (NUM_CMDS),
    .CMD_W    (CMD_W),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (seq_start),
    .byte_done (byte_done),
    .seq_len   (seq_len),
    .slot_cmd  (slot_cmd),
    .slot_len  (slot_len),
    .ptr_o     (ptr),
    .cs_o      (cs_active),
    .active_o  (cmd_active),
    .cmd_o     (cur_cmd),
    .left_o    (bytes_left),
    .busy_o    (seq_busy),
    .done_o    (seq_done),
    .err_o     (err)
  );

  assign cur_mode   = cur_cmd[MODE_HI:MODE_LO];
  assign cur_read   = (cur_mode != MODE_SINGLE) && cur_cmd[DIR_BIT];
  assign seq_status = {1'b0, err, 1'b0, ptr};

endmodule

// File: tb/spi_cmd_seq_bench.sv
module spi_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        seq_start;
  logic        byte_done;
  logic        cs_active, cmd_active, cur_read, seq_busy, seq_done;
  logic [15:0] cur_cmd;
  logic [1:0]  cur_mode;
  logic [31:0] bytes_left;
  logic [7:0]  seq_status;

  always #5 clk = ~clk;

  spi_cmd_seq u_spi_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seq_start(seq_start), .byte_done(byte_done), .cs_active(cs_active),
    .cmd_active(cmd_active), .cur_cmd(cur_cmd), .cur_mode(cur_mode),
    .cur_read(cur_read), .bytes_left(bytes_left), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_status(seq_status)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // behavioural reference
  logic [15:0] m_cmd [4];
  logic [31:0] m_len [4];
  int m_seqlen, m_phase, m_ptr, m_err;
  int unsigned m_left;
  logic [15:0] m_cur;
  bit m_cs, m_done;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_ptr = 0; m_err = 0; m_left = 0; m_cur = '0;
      m_cs = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (seq_start) begin
          if (m_seqlen > 3) m_err = 1;
          else begin m_err = 0; m_ptr = 0; m_phase = 1; end
        end
      end else if (m_phase == 1) begin
        if (m_len[m_ptr] == 0) begin
          if (m_ptr == m_seqlen) begin m_phase = 0; m_ptr = 0; m_cs = 0; m_done = 1; end
          else m_ptr++;
        end else begin
          m_cur = m_cmd[m_ptr]; m_left = m_len[m_ptr]; m_cs = 1; m_phase = 2;
        end
      end else begin
        if (byte_done) begin
          m_left--;
          if (m_left == 0) begin
            if (m_ptr == m_seqlen) begin m_phase = 0; m_ptr = 0; m_cs = 0; m_done = 1; end
            else begin m_ptr++; m_cs = m_cur[7]; m_phase = 1; end
          end
        end
      end
    end
  end

  // engine model: one byte every 'period' active cycles
  int period = 1;
  int bd_cnt = 0;
  int bytes_sent = 0;
  bit cs_seen = 0;

  always @(negedge clk) begin
    if (rst || !cmd_active) begin
      byte_done = 1'b0;
      bd_cnt = 0;
    end else begin
      bd_cnt++;
      byte_done = (bd_cnt % period == 0);
      if (byte_done) bytes_sent++;
    end
    if (cs_active) cs_seen = 1;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R6", "cs_active", cs_active, m_cs);
      check("R3", "cmd_active", cmd_active, m_phase == 2);
      check("R11", "seq_busy", seq_busy, m_phase != 0);
      check("R8", "seq_done", seq_done, m_done);
      check("R5", "seq_status", seq_status, {1'b0, 3'(m_err), 1'b0, 3'(m_ptr)});
      if (m_phase == 2) begin
        check("R2", "cur_cmd", cur_cmd, m_cur);
        check("R3", "cur_mode", cur_mode, m_cur[6:5]);
        check("R3", "cur_read", cur_read, (m_cur[6:5] != 2'b00) && m_cur[4]);
        check("R4", "bytes_left", bytes_left, m_left);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 8'h08) m_seqlen = int'(d[2:0]);
    for (int i = 0; i < 4; i++) begin
      if (a == 8'(16 + 2 * i)) m_cmd[i] = d[15:0];
      if (a == 8'(32 + 4 * i)) m_len[i] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      if (seq_done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_cmd[i] = '0; m_len[i] = '0; end
    m_seqlen = 0;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; seq_start = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cs reset", cs_active, 0);
    check("R1", "active reset", cmd_active, 0);
    check("R1", "busy reset", seq_busy, 0);
    check("R1", "status reset", seq_status, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done after reset", seq_done, 0);

    // R10: only the count of slot 0 programmed; sequence length still 0
    wr(8'h20, 32'd3);
    wr(8'h24, 32'd5);
    bytes_sent = 0;
    pulse_start();
    wait_done();
    check("R10", "bytes with reset length", bytes_sent, 3);

    // R3 R6 R7: four slots, one skipped, mixed hold bits, one byte per cycle
    wr(8'h10, 32'h000000C0);
    wr(8'h12, 32'h00000030);
    wr(8'h14, 32'h00000050);
    wr(8'h16, 32'h000000A0);
    wr(8'h20, 32'd2);
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd3);
    wr(8'h2C, 32'd1);
    wr(8'h08, 32'd3);
    bytes_sent = 0;
    pulse_start();
    wait_done();
    check("R3", "bytes over four slots", bytes_sent, 6);

    // R11: a start mid-run is ignored; slower engine
    period = 3;
    wr(8'h08, 32'd1);
    wr(8'h20, 32'd4);
    wr(8'h24, 32'd2);
    wr(8'h12, 32'h00000040);
    bytes_sent = 0;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    wait_done();
    check("R11", "bytes with start mid-run", bytes_sent, 6);
    repeat (3) @(negedge clk);
    check("R11", "idle after run", seq_busy, 0);

    // R9: sequence length beyond the slots
    period = 1;
    wr(8'h08, 32'd5);
    pulse_start();
    @(negedge clk);
    check("R9", "error code", seq_status[6:4], 1);
    check("R9", "not started", seq_busy, 0);
    check("R9", "select low", cs_active, 0);
    wr(8'h08, 32'd0);
    pulse_start();
    check("R9", "error cleared", seq_status[6:4], 0);
    wait_done();

    // R7: every count zero, no select at all
    wr(8'h08, 32'd3);
    wr(8'h20, 32'd0);
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd0);
    wr(8'h2C, 32'd0);
    cs_seen = 0;
    bytes_sent = 0;
    pulse_start();
    wait_done();
    check("R7", "select never raised", cs_seen, 0);
    check("R7", "no bytes issued", bytes_sent, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule